// File: doc/BRIEF.md
# Zero-Voltage-Switching Drive Sequencer

This block sequences the gate drive of a single power switch in a resonant converter. A 16-bit digital ramp takes the place of a timing capacitor. While the switch is off, the ramp climbs by a programmable charge step every cycle. While the switch is on, it falls by a programmable discharge step. The largest off time therefore scales inversely with the charge step, and the on time scales inversely with the discharge step. The on time ends when the ramp gets back to its floor level. The off time ends when the ramp reaches its ceiling level, which is three times the floor. It can also end sooner, when an external comparator reports that the switch's drain has fallen to zero volts.

That early turn-on is blanked until the ramp has climbed past a level one and a half times the floor. The blanking stops the switch from turning straight back on after it turns off. An over-current indication does three things: it empties the ramp at once, it latches a limit flag that holds the drive low, and it blocks the zero-voltage path. The limit flag lets go only after the drive latch has dropped. The block also takes an enable, a reference-good flag and an external overdissipation trip, and gates the drive request with all of them. A phase code tells the surrounding logic which state the sequencer is in.

Top module: `zvs_drive_seq`

## Requirements
- R1: While rst_n is low, and for two clock edges after it rises, ramp_o equals the floor level (default 4096) and gate_o is 0.
- R2: In the charge phase (phase_o = 1), the ramp rises by charge_rate_i on each clock and gate_o is 0.
- R3: In the discharge phase (phase_o = 2), the ramp falls by discharge_rate_i on each clock. When the next value would be at or below the floor, the ramp is set to the floor and the drive latch clears.
- R4: In the charge phase, when ramp plus charge_rate_i reaches the ceiling (3 × floor, default 12288), the ramp is clamped to the ceiling and the drive latch sets on that clock.
- R5: In the charge phase, a high zv_det_i sets the drive latch and holds the ramp value. It has this effect only when the ramp is strictly above the blanking level (1.5 × floor, default 6144) and the limit latch is clear.
- R6: A high ilim_i while running sets the ramp to the floor on the next clock, sets the limit latch (phase_o = 3), and blocks both zero-voltage and ceiling turn-on on that clock.
- R7: The limit latch stays set while the drive latch is set. It clears on the first clock at which the drive latch is already clear and ilim_i is low.
- R8: gate_o is 1 exactly when all of these hold: the drive latch is set, the limit latch is clear, odp_trip_i is low, enable_i is high and ref_ok_i is high.
- R9: With enable_i or ref_ok_i low, phase_o is 0. On the next clock the ramp goes to the floor and both latches clear, so a restart begins with a full off period.
- R10: ramp_o always stays between the floor and the ceiling, inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run request |
| ref_ok_i | input | 1 | Reference supply is good |
| odp_trip_i | input | 1 | External overdissipation trip, inhibits drive |
| zv_det_i | input | 1 | Drain below the zero-voltage threshold |
| ilim_i | input | 1 | Switch current above the limit |
| charge_rate_i | input | 12 | Ramp step per cycle in the off phase |
| discharge_rate_i | input | 12 | Ramp step per cycle in the on phase |
| gate_o | output | 1 | Gate-drive request |
| phase_o | output | 2 | 0 idle, 1 charge, 2 discharge, 3 current limit |
| ramp_o | output | 16 | Present ramp value |

## Verification
The assertions check these properties on every cycle:
- the ramp stays within its bounds;
- the gate stays low in the charge phase;
- a current-limit hit or a loss of enable leaves the ramp at the floor on the next cycle;
- the ramp never rises in the discharge phase;
- no turn-on happens from below the blanking level with a small step.

The bench's reference model is needed to show the exact step sizes, the ceiling clamp, the zero-voltage early turn-on just above the blanking level, and the cycle at which the limit latch lets go after the drive latch drops.

// File: rtl/zvs_pkg.sv
package zvs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE      = 2'd0,
    PH_CHARGE    = 2'd1,
    PH_DISCHARGE = 2'd2,
    PH_LIMIT     = 2'd3
  } zvs_phase_e;

endpackage

// File: rtl/zvs_rst_sync.sv
module zvs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/zvs_ramp.sv
module zvs_ramp #(
  parameter int RAMP_W  = 16,
  parameter int RATE_W  = 12,
  parameter int RAMP_LO = 4096,
  parameter int RAMP_HI = 3 * RAMP_LO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              dump,
  input  logic              drv_q,
  input  logic              zv_take,
  input  logic [RATE_W-1:0] charge_rate,
  input  logic [RATE_W-1:0] discharge_rate,
  output logic [RAMP_W-1:0] ramp_q,
  output logic              at_top,
  output logic              at_bottom,
  output logic              above_mid
);
  localparam int SUM_W  = RAMP_W + 1;
  localparam int MID    = RAMP_LO + (RAMP_HI - RAMP_LO) / 4;
  localparam logic [RAMP_W-1:0] LO_V  = RAMP_W'(RAMP_LO);
  localparam logic [RAMP_W-1:0] HI_V  = RAMP_W'(RAMP_HI);
  localparam logic [RAMP_W-1:0] MID_V = RAMP_W'(MID);

  logic [SUM_W-1:0]  up_sum;
  logic [SUM_W-1:0]  floor_sum;
  logic [RAMP_W-1:0] ramp_d;
  logic              ramp_en;

  always_comb begin
    up_sum    = {1'b0, ramp_q} + SUM_W'(charge_rate);
    floor_sum = SUM_W'(LO_V) + SUM_W'(discharge_rate);
    at_top    = up_sum >= SUM_W'(HI_V);
    at_bottom = {1'b0, ramp_q} <= floor_sum;
    above_mid = ramp_q > MID_V;
  end

  always_comb begin
    ramp_d = ramp_q;
    if (!run || dump) begin
      ramp_d = LO_V;
    end else if (drv_q) begin
      if (at_bottom) ramp_d = LO_V;
      else           ramp_d = ramp_q - RAMP_W'(discharge_rate);
    end else if (zv_take) begin
      ramp_d = ramp_q;
    end else if (at_top) begin
      ramp_d = HI_V;
    end else begin
      ramp_d = up_sum[RAMP_W-1:0];
    end
    ramp_en = ramp_d != ramp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ramp_q <= LO_V;
    else if (ramp_en) ramp_q <= ramp_d;
  end
endmodule

// File: rtl/zvs_latches.sv
module zvs_latches (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ilim,
  input  logic zv_det,
  input  logic at_top,
  input  logic at_bottom,
  input  logic above_mid,
  output logic drv_q,
  output logic cl_q,
  output logic zv_take
);
  logic drv_d, cl_d;

  always_comb begin
    zv_take = zv_det && above_mid && !cl_q && !drv_q && !ilim;
    if (!run)       drv_d = 1'b0;
    else if (drv_q) drv_d = !at_bottom;
    else            drv_d = !ilim && (zv_take || at_top);
    cl_d = run && (ilim || (cl_q && drv_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= 1'b0;
      cl_q  <= 1'b0;
    end else begin
      if (drv_d != drv_q) drv_q <= drv_d;
      if (cl_d != cl_q)   cl_q  <= cl_d;
    end
  end
endmodule

// File: rtl/zvs_gate.sv
module zvs_gate
  import zvs_pkg::*;
(
  input  logic       drv_q,
  input  logic       cl_q,
  input  logic       odp_trip,
  input  logic       enable,
  input  logic       ref_ok,
  output logic       gate,
  output zvs_phase_e phase
);
  always_comb begin
    gate = drv_q && !cl_q && !odp_trip && enable && ref_ok;
    if (!(enable && ref_ok)) phase = PH_IDLE;
    else if (cl_q)           phase = PH_LIMIT;
    else if (drv_q)          phase = PH_DISCHARGE;
    else                     phase = PH_CHARGE;
  end
endmodule

// File: rtl/zvs_drive_seq.sv
module zvs_drive_seq
  import zvs_pkg::*;
#(
  parameter int RAMP_W  = 16,
  parameter int RATE_W  = 12,
  parameter int RAMP_LO = 4096,
  parameter int RAMP_HI = 3 * RAMP_LO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              ref_ok_i,
  input  logic              odp_trip_i,
  input  logic              zv_det_i,
  input  logic              ilim_i,
  input  logic [RATE_W-1:0] charge_rate_i,
  input  logic [RATE_W-1:0] discharge_rate_i,
  output logic              gate_o,
  output logic [1:0]        phase_o,
  output logic [RAMP_W-1:0] ramp_o
);
  logic       rst_n_int;
  logic       run;
  logic       drv_q, cl_q, zv_take;
  logic       at_top, at_bottom, above_mid;
  zvs_phase_e phase;

  assign run = enable_i && ref_ok_i;

  zvs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  zvs_ramp #(
    .RAMP_W(RAMP_W), .RATE_W(RATE_W), .RAMP_LO(RAMP_LO), .RAMP_HI(RAMP_HI)
  ) u_ramp (
    .clk(clk), .rst_n(rst_n_int), .run(run), .dump(ilim_i), .drv_q(drv_q),
    .zv_take(zv_take), .charge_rate(charge_rate_i),
    .discharge_rate(discharge_rate_i), .ramp_q(ramp_o), .at_top(at_top),
    .at_bottom(at_bottom), .above_mid(above_mid)
  );

  zvs_latches u_latch (
    .clk(clk), .rst_n(rst_n_int), .run(run), .ilim(ilim_i), .zv_det(zv_det_i),
    .at_top(at_top), .at_bottom(at_bottom), .above_mid(above_mid),
    .drv_q(drv_q), .cl_q(cl_q), .zv_take(zv_take)
  );

  zvs_gate u_gate (
    .drv_q(drv_q), .cl_q(cl_q), .odp_trip(odp_trip_i), .enable(enable_i),
    .ref_ok(ref_ok_i), .gate(gate_o), .phase(phase)
  );

  assign phase_o = phase;
endmodule

// File: rtl/zvs_drive_seq_chk.sv
module zvs_drive_seq_chk #(
  parameter int RAMP_W  = 16,
  parameter int RATE_W  = 12,
  parameter int RAMP_LO = 4096,
  parameter int RAMP_HI = 3 * RAMP_LO
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable_i,
  input logic              ref_ok_i,
  input logic              ilim_i,
  input logic [RATE_W-1:0] charge_rate_i,
  input logic              gate_o,
  input logic [1:0]        phase_o,
  input logic [RAMP_W-1:0] ramp_o
);
  localparam int MID = RAMP_LO + (RAMP_HI - RAMP_LO) / 4;
  logic run;
  assign run = enable_i && ref_ok_i;

  assert_ramp_bounds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_o >= RAMP_W'(RAMP_LO)) && (ramp_o <= RAMP_W'(RAMP_HI)));

  assert_gate_low_charge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd1) |-> !gate_o);

  assert_ilim_dump_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ilim_i) |=> (ramp_o == RAMP_W'(RAMP_LO)) && !gate_o);

  assert_stop_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (ramp_o == RAMP_W'(RAMP_LO)) && !gate_o);

  assert_no_rise_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd2) |=> ramp_o <= $past(ramp_o));

  assert_blanking_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase_o == 2'd1 && ramp_o <= RAMP_W'(MID) &&
     ({1'b0, ramp_o} + (RAMP_W+1)'(charge_rate_i) < (RAMP_W+1)'(RAMP_HI)))
    |=> phase_o != 2'd2);
endmodule

bind zvs_drive_seq zvs_drive_seq_chk #(
  .RAMP_W(RAMP_W), .RATE_W(RATE_W), .RAMP_LO(RAMP_LO), .RAMP_HI(RAMP_HI)
) i_chk (
  .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .ref_ok_i(ref_ok_i),
  .ilim_i(ilim_i), .charge_rate_i(charge_rate_i), .gate_o(gate_o),
  .phase_o(phase_o), .ramp_o(ramp_o)
);

// File: tb/test_zvs_drive_seq.sv
module test_zvs_drive_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LO  = 4096;
  localparam int HI  = 3 * LO;
  localparam int MID = LO + (HI - LO) / 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable_i, ref_ok_i, odp_trip_i, zv_det_i, ilim_i;
  logic [11:0] charge_rate_i, discharge_rate_i;
  logic        gate_o;
  logic [1:0]  phase_o;
  logic [15:0] ramp_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int    m_ramp;
  bit    m_drv, m_cl;
  string m_tag;

  zvs_drive_seq i_zvs_drive_seq (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .ref_ok_i(ref_ok_i),
    .odp_trip_i(odp_trip_i), .zv_det_i(zv_det_i), .ilim_i(ilim_i),
    .charge_rate_i(charge_rate_i), .discharge_rate_i(discharge_rate_i),
    .gate_o(gate_o), .phase_o(phase_o), .ramp_o(ramp_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model built from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ramp = LO; m_drv = 0; m_cl = 0; m_tag = "R1";
    end else begin
      bit ncl;
      if (!(enable_i && ref_ok_i)) begin
        m_ramp = LO; m_drv = 0; m_cl = 0; m_tag = "R9";
      end else begin
        ncl = ilim_i || (m_cl && m_drv);
        if (m_drv) begin
          if (m_ramp <= LO + int'(discharge_rate_i)) begin
            m_ramp = LO; m_drv = 0; m_tag = "R3";
          end else if (ilim_i) begin
            m_ramp = LO; m_tag = "R6";
          end else begin
            m_ramp = m_ramp - int'(discharge_rate_i); m_tag = "R3";
          end
        end else if (ilim_i) begin
          m_ramp = LO; m_tag = "R6";
        end else if (zv_det_i && m_ramp > MID && !m_cl) begin
          m_drv = 1; m_tag = "R5";
        end else if (m_ramp + int'(charge_rate_i) >= HI) begin
          m_ramp = HI; m_drv = 1; m_tag = "R4";
        end else begin
          m_ramp = m_ramp + int'(charge_rate_i); m_tag = "R2";
        end
        m_cl = ncl;
      end
    end
  end

  function automatic bit exp_gate();
    return m_drv && !m_cl && !odp_trip_i && enable_i && ref_ok_i;
  endfunction

  function automatic int exp_phase();
    if (!(enable_i && ref_ok_i)) return 0;
    if (m_cl)  return 3;
    if (m_drv) return 2;
    return 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(m_tag, int'(ramp_o), m_ramp);
    check("R8", int'(gate_o), int'(exp_gate()));
    check(m_cl ? "R7" : "R9", int'(phase_o), exp_phase());
    check("R10", int'(ramp_o >= 16'(LO) && ramp_o <= 16'(HI)), 1);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; enable_i = 0; ref_ok_i = 0; odp_trip_i = 0;
    zv_det_i = 0; ilim_i = 0; charge_rate_i = 12'd1000; discharge_rate_i = 12'd1000;
    repeat (3) @(negedge clk);
    check("R1", int'(ramp_o), LO);
    check("R1", int'(gate_o), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1", int'(ramp_o), LO);
    check("R1", int'(gate_o), 0);
    step();

    // Directed: full off period to the ceiling, then discharge (R2, R4, R3)
    enable_i = 1; ref_ok_i = 1; #1;
    for (int i = 0; i < 30; i++) begin compare_all(); step(); #1; end

    // Directed: zero-voltage held high, blanking then early turn-on (R5)
    enable_i = 0; step(); enable_i = 1; charge_rate_i = 12'd500; zv_det_i = 1; #1;
    for (int i = 0; i < 12; i++) begin compare_all(); step(); #1; end
    zv_det_i = 0;

    // Directed: current limit in the discharge phase (R6, R7)
    for (int i = 0; i < 30; i++) begin
      ilim_i = (phase_o == 2'd2 && i < 25) ? 1'b1 : 1'b0; #1;
      compare_all(); step(); ilim_i = 0; #1;
    end

    // Constrained random mix
    for (int i = 0; i < 6000; i++) begin
      if (i % 150 == 0) begin
        charge_rate_i    = 12'(100 + $urandom_range(0, 1500));
        discharge_rate_i = 12'(100 + $urandom_range(0, 1500));
      end
      enable_i   = ($urandom_range(0, 99) != 0);
      ref_ok_i   = ($urandom_range(0, 99) != 0);
      odp_trip_i = ($urandom_range(0, 19) == 0);
      ilim_i     = ($urandom_range(0, 29) == 0);
      zv_det_i   = ($urandom_range(0, 3) == 0);
      #1;
      compare_all();
      step();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule